// File: doc/BRIEF.md
# Width-Selectable Serial Transmit Register

This block stages one outgoing word between a parallel writer and a serial output. A processor core or a DMA engine places a 24-bit word into a holding register. A frame strobe then copies that word into a shift register. Each bit-clock tick then moves one bit onto the serial output, most significant bit first. A word-size input sets how many bytes of the word leave the block: one, two or three, always counted from the top byte.

A transmit-empty flag tells the writer when the holding register may take the next word. A write clears the flag and the frame strobe sets it again. An interrupt output goes high while the flag is set and the interrupt enable is high. Hardware reset, software reset, a block-local reset and stop mode all return the register to its empty, idle state.

The serial side runs in the block clock domain. The bit clock and the frame strobe arrive as single-cycle enables that have already been synchronised.

Top module: `wsel_tx_reg`

## Requirements
- R1: When `rst_n` is released, `tx_empty` is 1, `ser_active` is 0, `ser_data` is 0, and `tx_irq` is 0 while `tx_ie` is 0.
- R2: A write on either port (`wr_core_en` or `wr_dma_en`) stores its data and clears `tx_empty` one clock later. If both ports write in the same cycle, the core data is stored.
- R3: A write made while `tx_empty` is 0 replaces the pending word, so the next frame sends the data of the last write.
- R4: On a `frame_sync` cycle the holding word is copied into the shifter, `ser_active` rises and `tx_empty` is set. If a write occurs in that same cycle, the frame carries the old word, and the new word stays pending with `tx_empty` at 0.
- R5: `tx_irq` is high exactly when `tx_empty` is 1 and `tx_ie` is 1.
- R6: `word_mode` encodes the size: 0 sends bits 23..16 (8 bits), 1 sends bits 23..8 (16 bits), and 2 or 3 send bits 23..0 (24 bits). `ser_active` falls after that many bit ticks.
- R7: Right after frame start, `ser_data` shows bit 23. Each `bit_tick` during the frame moves to the next lower bit. Without a tick, `ser_data` holds its value.
- R8: While `ser_active` is 0, `ser_data` is 0, and `bit_tick` has no effect.
- R9: A `sw_rst` or `blk_rst` pulse aborts any frame, clears the holding word to zero and sets `tx_empty`.
- R10: While `stop_mode` is 1, the block stays empty and idle: writes and `frame_sync` are ignored.
- R11: A frame started while `tx_empty` is 1 sends the holding word again, which is the last word written, or zero after a reset.
- R12: The word size is captured at frame start. Changing `word_mode` during a frame does not change the length of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset pulse |
| blk_rst | input | 1 | Block-local reset pulse |
| stop_mode | input | 1 | Stop mode level; holds the block empty |
| wr_core_en | input | 1 | Core write strobe |
| wr_core_data | input | 24 | Core write data |
| wr_dma_en | input | 1 | DMA write strobe |
| wr_dma_data | input | 24 | DMA write data |
| word_mode | input | 2 | Word size: 0 = 8 bits, 1 = 16 bits, 2/3 = 24 bits |
| tx_ie | input | 1 | Transmit interrupt enable |
| frame_sync | input | 1 | Frame start enable, one cycle |
| bit_tick | input | 1 | Serial bit-clock enable, one cycle per bit |
| tx_empty | output | 1 | Holding register can accept a word |
| tx_irq | output | 1 | Transmit interrupt request |
| ser_data | output | 1 | Serial output bit |
| ser_active | output | 1 | Frame in progress |

## Verification
The assertions assume the following about the inputs:
- Every input is a clean synchronous level or pulse in the `clk` domain.
- `bit_tick` and `frame_sync` have already been brought into that domain.
- No input is unknown once reset is released.

The bench drives every input from time zero and changes inputs only one time unit after a rising edge. Strobes are held for exactly one cycle, so each property sees well-formed single-cycle enables.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    WM_BYTE  = 2'd0,
    WM_HALF  = 2'd1,
    WM_FULL  = 2'd2,
    WM_FULLB = 2'd3
  } wmode_t;

  // number of upper bytes sent for a mode, limited to the word's byte count
  function automatic int unsigned mode_bytes(input logic [1:0] m, input int unsigned max_b);
    int unsigned b;
    b = int'(m) + 1;
    return (b > max_b) ? max_b : b;
  endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              core_we,
  input  logic [DATA_W-1:0] core_d,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_d,
  output logic [DATA_W-1:0] hold_q,
  output logic              empty_q
);

  logic [DATA_W-1:0] hold_d;
  logic              empty_d;
  logic              hold_en;

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    if (clr) begin
      hold_d  = '0;
      empty_d = 1'b1;
    end else begin
      if (load) empty_d = 1'b1;
      if (core_we) begin
        hold_d  = core_d;
        empty_d = 1'b0;
      end else if (dma_we) begin
        hold_d  = dma_d;
        empty_d = 1'b0;
      end
    end
  end

  assign hold_en = clr | core_we | dma_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
    end else begin
      empty_q <= empty_d;
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] hold_q,
  input  logic              bit_tick,
  output logic              ser_data,
  output logic              active_q
);

  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] masked;
  logic [NBYTES-1:0] keep;
  logic [CNT_W-1:0]  nbits;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              active_d;
  logic              sh_en;

  always_comb begin
    nbits = CNT_W'(mode_bytes(mode, NBYTES) * BYTE_W);
  end

  // byte b counts down from the top of the word
  for (genvar b = 0; b < NBYTES; b++) begin : g_bytesel
    assign keep[b] = (b < int'(mode_bytes(mode, NBYTES)));
    assign masked[DATA_W-1-b*BYTE_W -: BYTE_W] =
      keep[b] ? hold_q[DATA_W-1-b*BYTE_W -: BYTE_W] : '0;
  end

  always_comb begin
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    if (clr) begin
      sh_d     = '0;
      cnt_d    = '0;
      active_d = 1'b0;
    end else if (load) begin
      sh_d     = masked;
      cnt_d    = nbits;
      active_d = 1'b1;
    end else if (active_q && bit_tick) begin
      sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) active_d = 1'b0;
    end
  end

  assign sh_en = clr | load | (active_q & bit_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (sh_en) begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  assign ser_data = active_q & sh_q[DATA_W-1];

endmodule

// File: rtl/wsel_tx_reg.sv
module wsel_tx_reg #(
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              blk_rst,
  input  logic              stop_mode,
  input  logic              wr_core_en,
  input  logic [DATA_W-1:0] wr_core_data,
  input  logic              wr_dma_en,
  input  logic [DATA_W-1:0] wr_dma_data,
  input  logic [1:0]        word_mode,
  input  logic              tx_ie,
  input  logic              frame_sync,
  input  logic              bit_tick,
  output logic              tx_empty,
  output logic              tx_irq,
  output logic              ser_data,
  output logic              ser_active
);

  logic              clr;
  logic [DATA_W-1:0] hold_q;

  assign clr = sw_rst | blk_rst | stop_mode;

  sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (frame_sync),
    .core_we (wr_core_en),
    .core_d  (wr_core_data),
    .dma_we  (wr_dma_en),
    .dma_d   (wr_dma_data),
    .hold_q  (hold_q),
    .empty_q (tx_empty)
  );

  sertx_shifter #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (frame_sync),
    .mode     (word_mode),
    .hold_q   (hold_q),
    .bit_tick (bit_tick),
    .ser_data (ser_data),
    .active_q (ser_active)
  );

  assign tx_irq = tx_empty & tx_ie;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic              blk_rst,
  input logic              stop_mode,
  input logic              wr_core_en,
  input logic [DATA_W-1:0] wr_core_data,
  input logic              wr_dma_en,
  input logic [DATA_W-1:0] wr_dma_data,
  input logic [1:0]        word_mode,
  input logic              tx_ie,
  input logic              frame_sync,
  input logic              bit_tick,
  input logic              tx_empty,
  input logic              tx_irq,
  input logic              ser_data,
  input logic              ser_active
);

  logic any_clr, any_wr;
  assign any_clr = sw_rst | blk_rst | stop_mode;
  assign any_wr  = wr_core_en | wr_dma_en;

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr && !any_clr |=> !tx_empty); // R2

  AST_FRAME_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !any_clr && !any_wr |=> tx_empty); // R4

  AST_FRAME_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !any_clr |=> ser_active); // R4

  AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_empty); // R5

  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ser_active && !bit_tick && !frame_sync && !any_clr |=> ser_active && $stable(ser_data)); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_active |-> !ser_data); // R8

  AST_CLR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst || blk_rst) |=> tx_empty && !ser_active); // R9

  AST_STOP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> tx_empty && !ser_active); // R10

endmodule

bind wsel_tx_reg sertx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/wsel_tx_reg_tb.sv
`timescale 1ns/1ps
module wsel_tx_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0, blk_rst = 1'b0, stop_mode = 1'b0;
  logic        wr_core_en = 1'b0, wr_dma_en = 1'b0;
  logic [23:0] wr_core_data = '0, wr_dma_data = '0;
  logic [1:0]  word_mode = 2'd0;
  logic        tx_ie = 1'b0, frame_sync = 1'b0, bit_tick = 1'b0;
  logic        tx_empty, tx_irq, ser_data, ser_active;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wsel_tx_reg u_dut (.*);

  // {mode[1:0], data[23:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 24'hA53C7E}, {2'd1, 24'hC35A11}, {2'd2, 24'h800001}, {2'd3, 24'h5AA5FF},
    {2'd0, 24'hFF0000}, {2'd1, 24'h0180FE}, {2'd2, 24'hDEAD37}, {2'd0, 24'h00FFFF}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] m);
    return (m >= 2) ? 24 : (int'(m) + 1) * 8;
  endfunction

  task automatic wr_core(input logic [23:0] d);
    wr_core_en = 1'b1; wr_core_data = d; tick(); wr_core_en = 1'b0;
  endtask

  task automatic wr_dma(input logic [23:0] d);
    wr_dma_en = 1'b1; wr_dma_data = d; tick(); wr_dma_en = 1'b0;
  endtask

  // start a frame and collect n bits; gap inserts idle cycles between ticks
  task automatic collect(input int n, input int gap, output logic [23:0] got, output logic act_end);
    got = '0;
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    for (int i = 0; i < n; i++) begin
      got = {got[22:0], ser_data};
      for (int g = 0; g < gap; g++) tick();
      bit_tick = 1'b1; tick(); bit_tick = 1'b0;
    end
    act_end = ser_active;
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] got;
    logic        act_end;
    int          n;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 empty", tx_empty, 1);
    check("R1 active", ser_active, 0);
    check("R1 data", ser_data, 0);
    check("R1 irq", tx_irq, 0);
    tx_ie = 1'b1; #1;
    check("R5 irq when empty", tx_irq, 1);

    // table walk: R6, R7, R2
    for (int v = 0; v < 8; v++) begin
      logic [1:0]  m;
      logic [23:0] d;
      m = VEC[v][25:24]; d = VEC[v][23:0];
      n = nbits_of(m);
      word_mode = m;
      if (v % 2 == 0) wr_core(d); else wr_dma(d);
      check("R2 empty cleared", tx_empty, 0);
      check("R5 irq low", tx_irq, 0);
      collect(n, v % 3, got, act_end);
      check("R6/R7 bits", got, d >> (24 - n));
      check("R6 frame ended", act_end, 0);
      check("R4 empty set", tx_empty, 1);
    end

    // R2 both ports same cycle: core wins
    word_mode = 2'd2;
    wr_core_en = 1'b1; wr_core_data = 24'h123456;
    wr_dma_en  = 1'b1; wr_dma_data  = 24'hFEDCBA;
    tick(); wr_core_en = 1'b0; wr_dma_en = 1'b0;
    collect(24, 0, got, act_end);
    check("R2 core priority", got, 24'h123456);

    // R3 overwrite pending
    wr_core(24'h111111);
    wr_dma(24'h2B2B2B);
    collect(24, 0, got, act_end);
    check("R3 last write sent", got, 24'h2B2B2B);

    // R11 underrun resends
    collect(24, 0, got, act_end);
    check("R11 resend", got, 24'h2B2B2B);
    check("R11 still empty", tx_empty, 1);

    // R4 write during frame start cycle
    wr_core(24'hA0A0A0);
    wr_core_en = 1'b1; wr_core_data = 24'h0F0F0F; frame_sync = 1'b1;
    tick(); wr_core_en = 1'b0; frame_sync = 1'b0;
    check("R4 new word pending", tx_empty, 0);
    check("R4 first bit old word", ser_data, 1);
    got = 24'h800000;
    for (int i = 1; i < 24; i++) begin
      bit_tick = 1'b1; tick(); bit_tick = 1'b0;
      got[23-i] = ser_data;
    end
    check("R4 old word sent", got, 24'hA0A0A0);
    bit_tick = 1'b1; tick(); bit_tick = 1'b0;
    collect(24, 0, got, act_end);
    check("R4 pending word sent next", got, 24'h0F0F0F);

    // R12 mode captured at frame start
    word_mode = 2'd0;
    wr_core(24'hFFFFFF);
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    for (int i = 0; i < 2; i++) begin bit_tick = 1'b1; tick(); bit_tick = 1'b0; end
    word_mode = 2'd2;
    for (int i = 0; i < 6; i++) begin bit_tick = 1'b1; tick(); bit_tick = 1'b0; end
    check("R12 length kept", ser_active, 0);

    // R8 idle tick has no effect
    bit_tick = 1'b1; tick(); bit_tick = 1'b0;
    check("R8 idle active", ser_active, 0);
    check("R8 idle data", ser_data, 0);

    // R9 software reset mid-frame
    wr_core(24'hFFFFFF);
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    check("R7 first bit", ser_data, 1);
    sw_rst = 1'b1; tick(); sw_rst = 1'b0;
    check("R9 aborted", ser_active, 0);
    check("R9 empty", tx_empty, 1);
    collect(24, 0, got, act_end);
    check("R9 hold cleared", got, 24'h000000);

    // R9 block reset clears pending word
    wr_core(24'hC0FFEE);
    blk_rst = 1'b1; tick(); blk_rst = 1'b0;
    check("R9 blk empty", tx_empty, 1);
    collect(24, 0, got, act_end);
    check("R9 blk hold cleared", got, 24'h000000);

    // R10 stop mode ignores writes and frames
    stop_mode = 1'b1; tick();
    wr_core(24'hFFFFFF);
    check("R10 write ignored", tx_empty, 1);
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    check("R10 frame ignored", ser_active, 0);
    check("R5 irq in stop", tx_irq, 1);
    stop_mode = 1'b0; tick();
    collect(24, 0, got, act_end);
    check("R10 nothing stored", got, 24'h000000);

    // R1 hardware reset mid-frame
    wr_core(24'hFFFFFF);
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1; tx_ie = 1'b0; tick();
    check("R1 hw reset empty", tx_empty, 1);
    check("R1 hw reset active", ser_active, 0);
    check("R1 hw reset irq", tx_irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule